// File: doc/BRIEF.md
# Sequential Sector Disk Write Controller

This block is a stand-alone master for a parallel disk drive using the standard ATA task-file register set. No processor is involved. It moves fixed-length lines of 16-bit words from an upstream show-ahead FIFO onto consecutive drive sectors. After reset it waits until the drive reports ready. It then plays a short built-in list of register writes that sets the drive's transfer mode, and afterwards sits idle.

A `start` pulse loads a running sector counter from `base_lba` and begins a frame of `LINES` lines. For each line the controller does the following, in order:

1. It waits until the FIFO holds a whole line.
2. It polls status until the drive can take a command.
3. It programs a 28-bit logical block address and a sector count, then issues the write-sectors command.
4. Before every sector burst it polls for the data-request flag.
5. It sends `HDR_WORDS` header words, then the line's FIFO words, then zero words up to the end of the last sector.

The next line starts at the sector directly after the last one written. Every register access is a programmed-I/O cycle with address setup, a stretched strobe and a recovery cycle. An error bit in any status read latches a fault and stops all bus activity until reset.

Top module: `ata_seq_writer`

## Requirements
- R1: After reset release, the controller polls the status register (address 7) until BSY (bit 7) is 0 and DRDY (bit 6) is 1. It then writes, in this order and with no other write, register 1 = 0x03, register 2 = 0x08, register 6 = 0xE0 and register 7 = 0xEF, and then stays idle with `busy` low until `start`.
- R2: `start` in idle loads the sector counter with `base_lba`. The first line of the frame goes to `base_lba`, and each later line goes to the previous line's address plus SECTS, where SECTS = ceil((HDR_WORDS+LINE_WORDS)/SECT_WORDS). A new `start` restarts from the new base.
- R3: For each line the controller writes registers 2..7 in ascending order: sector count = SECTS, address bits 7:0 to register 3, 15:8 to register 4, 23:16 to register 5, register 6 = {4'hE, address bits 27:24}, and command 0x30 to register 7.
- R4: No task-file register is written for a line until a status read has returned BSY=0 and DRDY=1.
- R5: Each burst of SECT_WORDS data writes to register 0 is preceded by a status read returning BSY=0 and DRQ (bit 3) = 1. There are SECTS bursts per line.
- R6: Within a line, word k for k < HDR_WORDS is {k[3:0], line index within the frame [11:0]}. The next LINE_WORDS words are the FIFO words in FIFO order. The remaining words up to SECTS*SECT_WORDS are 0.
- R7: No command is issued for a line while `fifo_count` < LINE_WORDS. Exactly LINE_WORDS words are popped per line, and `fifo_rd` is never high while `fifo_count` is 0.
- R8: Address and write data are stable at least one clock before a strobe falls and for as long as it stays low. A strobe stays low for at least STROBE_CYC clocks. The read and write strobes are never low together.
- R9: `line_done` is high for exactly one clock after each line's last word. `busy` is high from the clock after `start` until the frame's last line is done, and low otherwise.
- R10: A status read with ERR (bit 0) set makes `fault` go high and stay high until reset. `busy` goes low, and no further strobe occurs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Begin a frame at `base_lba` (honoured in idle) |
| base_lba | input | 28 | First sector address of the frame |
| fifo_count | input | FCW | Words available in the upstream FIFO |
| fifo_data | input | 16 | Head word of the show-ahead FIFO |
| fifo_rd | output | 1 | Pop one word from the FIFO |
| ata_addr | output | 3 | Task-file register address |
| ata_dout | output | 16 | Write data to the drive |
| ata_dout_oe | output | 1 | Drive the data bus during a write cycle |
| ata_din | input | 8 | Low byte of the drive data bus (status) |
| ata_diow_n | output | 1 | Write strobe, active low |
| ata_dior_n | output | 1 | Read strobe, active low |
| busy | output | 1 | Frame in progress |
| line_done | output | 1 | One-clock pulse per finished line |
| fault | output | 1 | Sticky drive-error flag |

## Verification
A wrong sequencer state shows at the drive bus within one bus cycle, about five clocks. It appears as a register write while the modelled drive is still busy, a data word with no pending request, or an address byte or order that differs from the expected task file. A wrong word position or line counter shows as a mismatched header, payload or pad word at the exact word where it goes astray. A wrong address counter shows at the next line's command. The counts of FIFO pops and of `line_done` pulses, checked at the end of each frame, expose any extra or missing word or line.

// File: rtl/ata_seq_pkg.sv
package ata_seq_pkg;
  localparam int ST_BSY  = 7;
  localparam int ST_DRDY = 6;
  localparam int ST_DRQ  = 3;
  localparam int ST_ERR  = 0;

  localparam logic [2:0] RG_DATA  = 3'd0;
  localparam logic [2:0] RG_FEAT  = 3'd1;
  localparam logic [2:0] RG_NSECT = 3'd2;
  localparam logic [2:0] RG_LBA0  = 3'd3;
  localparam logic [2:0] RG_LBA1  = 3'd4;
  localparam logic [2:0] RG_LBA2  = 3'd5;
  localparam logic [2:0] RG_DEV   = 3'd6;
  localparam logic [2:0] RG_CMD   = 3'd7;

  localparam logic [7:0] CMD_WRSECT  = 8'h30;
  localparam logic [7:0] CMD_SETFEAT = 8'hEF;

  localparam int INIT_LEN = 4;

  typedef struct packed {
    logic [2:0] addr;
    logic [7:0] data;
  } tf_wr_t;

  typedef enum logic [3:0] {
    S_INIT_POLL, S_INIT_WR, S_IDLE, S_LINE_WAIT, S_CMD_POLL,
    S_TF_WR, S_DRQ_POLL, S_DATA, S_LINE_END, S_FAULT
  } ctl_st_t;
endpackage

// File: rtl/ata_init_rom.sv
module ata_init_rom
  import ata_seq_pkg::*;
(
  input  logic [1:0] idx,
  output tf_wr_t     ent
);
  always_comb begin
    unique case (idx)
      2'd0: ent = '{addr: RG_FEAT,  data: 8'h03};
      2'd1: ent = '{addr: RG_NSECT, data: 8'h08};
      2'd2: ent = '{addr: RG_DEV,   data: 8'hE0};
      default: ent = '{addr: RG_CMD, data: CMD_SETFEAT};
    endcase
  end
endmodule

// File: rtl/ata_word_src.sv
module ata_word_src #(
  parameter int HDR_WORDS  = 4,
  parameter int LINE_WORDS = 2304,
  parameter int POSW       = 12,
  parameter int LINEW      = 11
) (
  input  logic [POSW-1:0]  pos,
  input  logic [LINEW-1:0] line_idx,
  input  logic [15:0]      fifo_data,
  output logic [15:0]      word,
  output logic             from_fifo
);
  localparam logic [POSW-1:0] HDR_END = POSW'(HDR_WORDS);
  localparam logic [POSW-1:0] PAY_END = POSW'(HDR_WORDS + LINE_WORDS);

  always_comb begin
    from_fifo = 1'b0;
    if (pos < HDR_END) begin
      word = {4'(pos), 12'(line_idx)};
    end else if (pos < PAY_END) begin
      word      = fifo_data;
      from_fifo = 1'b1;
    end else begin
      word = 16'h0000;
    end
  end
endmodule

// File: rtl/ata_pio_cycle.sv
module ata_pio_cycle #(
  parameter int STROBE_CYC = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req,
  input  logic        req_we,
  input  logic [2:0]  req_addr,
  input  logic [15:0] req_wdata,
  input  logic [7:0]  ata_din,
  output logic        idle,
  output logic        done,
  output logic [7:0]  rdata,
  output logic [2:0]  ata_addr,
  output logic [15:0] ata_dout,
  output logic        ata_dout_oe,
  output logic        ata_diow_n,
  output logic        ata_dior_n
);
  localparam int CW = $clog2(STROBE_CYC + 1);
  localparam logic [CW-1:0] C_LAST = CW'(STROBE_CYC - 1);

  typedef enum logic [1:0] {E_IDLE, E_SETUP, E_STRB, E_RECOV} eng_st_t;

  eng_st_t       es, es_n;
  logic [CW-1:0] cnt, cnt_n;
  logic          we_q, lat_en, cap_en;
  logic [2:0]    addr_q;
  logic [15:0]   data_q;
  logic [7:0]    rd_q;

  always_comb begin
    es_n   = es;
    cnt_n  = cnt;
    lat_en = 1'b0;
    cap_en = 1'b0;
    unique case (es)
      E_IDLE:  if (req) begin es_n = E_SETUP; lat_en = 1'b1; end
      E_SETUP: begin es_n = E_STRB; cnt_n = '0; end
      E_STRB:  if (cnt == C_LAST) begin
                 es_n   = E_RECOV;
                 cap_en = ~we_q;
               end else begin
                 cnt_n = cnt + 1'b1;
               end
      default: es_n = E_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      es     <= E_IDLE;
      cnt    <= '0;
      we_q   <= 1'b0;
      addr_q <= 3'd0;
      data_q <= 16'h0000;
      rd_q   <= 8'h00;
    end else begin
      es  <= es_n;
      cnt <= cnt_n;
      if (lat_en) begin
        we_q   <= req_we;
        addr_q <= req_addr;
        data_q <= req_wdata;
      end
      if (cap_en) rd_q <= ata_din;
    end
  end

  assign idle        = (es == E_IDLE);
  assign done        = (es == E_RECOV);
  assign rdata       = rd_q;
  assign ata_addr    = addr_q;
  assign ata_dout    = data_q;
  assign ata_dout_oe = we_q && (es != E_IDLE);
  assign ata_diow_n  = !((es == E_STRB) && we_q);
  assign ata_dior_n  = !((es == E_STRB) && !we_q);
endmodule

// File: rtl/ata_seq_writer.sv
module ata_seq_writer
  import ata_seq_pkg::*;
#(
  parameter int LINE_WORDS  = 2304,
  parameter int HDR_WORDS   = 4,
  parameter int SECT_WORDS  = 256,
  parameter int LINES       = 1024,
  parameter int STROBE_CYC  = 2,
  parameter int FCW         = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [27:0]    base_lba,
  input  logic [FCW-1:0] fifo_count,
  input  logic [15:0]    fifo_data,
  output logic           fifo_rd,
  output logic [2:0]     ata_addr,
  output logic [15:0]    ata_dout,
  output logic           ata_dout_oe,
  input  logic [7:0]     ata_din,
  output logic           ata_diow_n,
  output logic           ata_dior_n,
  output logic           busy,
  output logic           line_done,
  output logic           fault
);
  localparam int TOT   = HDR_WORDS + LINE_WORDS;
  localparam int SECTS = (TOT + SECT_WORDS - 1) / SECT_WORDS;
  localparam int POSW  = $clog2(SECTS * SECT_WORDS + 1);
  localparam int WCW   = $clog2(SECT_WORDS);
  localparam int SCW   = $clog2(SECTS + 1);
  localparam int LINEW = $clog2(LINES + 1);
  localparam logic [WCW-1:0]   WC_LAST  = WCW'(SECT_WORDS - 1);
  localparam logic [SCW-1:0]   SC_LAST  = SCW'(SECTS - 1);
  localparam logic [LINEW-1:0] LN_LAST  = LINEW'(LINES - 1);
  localparam logic [FCW-1:0]   NEED     = FCW'(LINE_WORDS);
  localparam logic [7:0]       NSECT_B  = 8'(SECTS);
  localparam logic [27:0]      LBA_STEP = 28'(SECTS);
  localparam logic [2:0]       IDX_INIT_LAST = 3'(INIT_LEN - 1);

  logic [1:0] rst_q;
  logic       rst_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_i = rst_q[1];

  ctl_st_t          st, st_n;
  logic [2:0]       idx, idx_n;
  logic [WCW-1:0]   wc, wc_n;
  logic [SCW-1:0]   sc, sc_n;
  logic [POSW-1:0]  pos, pos_n;
  logic [27:0]      lba, lba_n;
  logic [LINEW-1:0] ln, ln_n;
  logic             iss, iss_n;

  logic        req, rq_we;
  logic [2:0]  rq_addr;
  logic [15:0] rq_wdata;
  logic        eng_idle, eng_done;
  logic [7:0]  sts;
  tf_wr_t      init_ent, tf_ent;
  logic [15:0] src_word;
  logic        src_fifo;
  logic        go;

  ata_init_rom u_rom (.idx(idx[1:0]), .ent(init_ent));

  ata_word_src #(
    .HDR_WORDS(HDR_WORDS), .LINE_WORDS(LINE_WORDS), .POSW(POSW), .LINEW(LINEW)
  ) u_src (
    .pos(pos), .line_idx(ln), .fifo_data(fifo_data),
    .word(src_word), .from_fifo(src_fifo)
  );

  ata_pio_cycle #(.STROBE_CYC(STROBE_CYC)) u_eng (
    .clk(clk), .rst_n(rst_i), .req(req), .req_we(rq_we), .req_addr(rq_addr),
    .req_wdata(rq_wdata), .ata_din(ata_din), .idle(eng_idle), .done(eng_done),
    .rdata(sts), .ata_addr(ata_addr), .ata_dout(ata_dout),
    .ata_dout_oe(ata_dout_oe), .ata_diow_n(ata_diow_n), .ata_dior_n(ata_dior_n)
  );

  // Per-line task-file programming list
  always_comb begin
    unique case (idx)
      3'd0:    tf_ent = '{addr: RG_NSECT, data: NSECT_B};
      3'd1:    tf_ent = '{addr: RG_LBA0,  data: lba[7:0]};
      3'd2:    tf_ent = '{addr: RG_LBA1,  data: lba[15:8]};
      3'd3:    tf_ent = '{addr: RG_LBA2,  data: lba[23:16]};
      3'd4:    tf_ent = '{addr: RG_DEV,   data: {4'hE, lba[27:24]}};
      default: tf_ent = '{addr: RG_CMD,   data: CMD_WRSECT};
    endcase
  end

  assign go = eng_idle && !iss;

  always_comb begin
    st_n     = st;
    idx_n    = idx;
    wc_n     = wc;
    sc_n     = sc;
    pos_n    = pos;
    lba_n    = lba;
    ln_n     = ln;
    iss_n    = iss && !eng_done;
    req      = 1'b0;
    rq_we    = 1'b0;
    rq_addr  = RG_CMD;
    rq_wdata = 16'h0000;
    fifo_rd  = 1'b0;
    unique case (st)
      S_INIT_POLL, S_CMD_POLL, S_DRQ_POLL: begin
        if (go) begin req = 1'b1; iss_n = 1'b1; end
        if (eng_done) begin
          if (sts[ST_ERR]) begin
            st_n = S_FAULT;
          end else if (st == S_DRQ_POLL) begin
            if (!sts[ST_BSY] && sts[ST_DRQ]) begin st_n = S_DATA; wc_n = '0; end
          end else if (!sts[ST_BSY] && sts[ST_DRDY]) begin
            st_n  = (st == S_INIT_POLL) ? S_INIT_WR : S_TF_WR;
            idx_n = 3'd0;
          end
        end
      end
      S_INIT_WR: begin
        if (go) begin
          req = 1'b1; iss_n = 1'b1; rq_we = 1'b1;
          rq_addr = init_ent.addr; rq_wdata = {8'h00, init_ent.data};
        end
        if (eng_done) begin
          if (idx == IDX_INIT_LAST) st_n = S_IDLE;
          else                      idx_n = idx + 3'd1;
        end
      end
      S_IDLE: if (start) begin
        lba_n = base_lba; ln_n = '0; st_n = S_LINE_WAIT;
      end
      S_LINE_WAIT: if (fifo_count >= NEED) st_n = S_CMD_POLL;
      S_TF_WR: begin
        if (go) begin
          req = 1'b1; iss_n = 1'b1; rq_we = 1'b1;
          rq_addr = tf_ent.addr; rq_wdata = {8'h00, tf_ent.data};
        end
        if (eng_done) begin
          if (idx == 3'd5) begin
            st_n = S_DRQ_POLL; sc_n = '0; pos_n = '0;
          end else begin
            idx_n = idx + 3'd1;
          end
        end
      end
      S_DATA: begin
        if (go) begin
          req = 1'b1; iss_n = 1'b1; rq_we = 1'b1;
          rq_addr = RG_DATA; rq_wdata = src_word; fifo_rd = src_fifo;
        end
        if (eng_done) begin
          pos_n = pos + 1'b1;
          wc_n  = wc + 1'b1;
          if (wc == WC_LAST) begin
            wc_n = '0;
            sc_n = sc + 1'b1;
            st_n = (sc == SC_LAST) ? S_LINE_END : S_DRQ_POLL;
          end
        end
      end
      S_LINE_END: begin
        lba_n = lba + LBA_STEP;
        ln_n  = ln + 1'b1;
        st_n  = (ln == LN_LAST) ? S_IDLE : S_LINE_WAIT;
      end
      default: st_n = S_FAULT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      st  <= S_INIT_POLL;
      idx <= 3'd0;
      wc  <= '0;
      sc  <= '0;
      pos <= '0;
      lba <= 28'd0;
      ln  <= '0;
      iss <= 1'b0;
    end else begin
      st  <= st_n;
      idx <= idx_n;
      wc  <= wc_n;
      sc  <= sc_n;
      pos <= pos_n;
      lba <= lba_n;
      ln  <= ln_n;
      iss <= iss_n;
    end
  end

  assign busy      = (st == S_LINE_WAIT) || (st == S_CMD_POLL) || (st == S_TF_WR) ||
                     (st == S_DRQ_POLL) || (st == S_DATA) || (st == S_LINE_END);
  assign line_done = (st == S_LINE_END);
  assign fault     = (st == S_FAULT);
endmodule

// File: rtl/ata_seq_checker.sv
module ata_seq_checker #(
  parameter int FCW        = 16,
  parameter int STROBE_CYC = 2
) (
  input logic           clk,
  input logic           rst_n,
  input logic           fifo_rd,
  input logic [FCW-1:0] fifo_count,
  input logic [2:0]     ata_addr,
  input logic [15:0]    ata_dout,
  input logic           ata_diow_n,
  input logic           ata_dior_n,
  input logic           busy,
  input logic           line_done,
  input logic           fault
);
  logic [7:0] lowc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           lowc <= 8'd0;
    else if (!ata_diow_n) lowc <= (lowc == 8'hFF) ? lowc : lowc + 8'd1;
    else                  lowc <= 8'd0;
  end

  assert_pop_nonempty_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_rd |-> (fifo_count != '0));

  assert_strobe_width_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ata_diow_n) |-> (32'(lowc) >= STROBE_CYC));

  assert_bus_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !ata_diow_n |-> ($stable(ata_addr) && $stable(ata_dout)));

  assert_one_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(!ata_diow_n && !ata_dior_n));

  assert_done_in_frame_R9: assert property (@(posedge clk) disable iff (!rst_n)
    line_done |-> busy);

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    line_done |=> !line_done);

  assert_fault_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> (fault && !busy && ata_diow_n && ata_dior_n));
endmodule

bind ata_seq_writer ata_seq_checker #(.FCW(FCW), .STROBE_CYC(STROBE_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .fifo_rd(fifo_rd), .fifo_count(fifo_count),
  .ata_addr(ata_addr), .ata_dout(ata_dout), .ata_diow_n(ata_diow_n),
  .ata_dior_n(ata_dior_n), .busy(busy), .line_done(line_done), .fault(fault)
);

// File: tb/test_ata_seq_writer.sv
module test_ata_seq_writer;
  localparam int LW  = 13;
  localparam int HW  = 2;
  localparam int SW  = 8;
  localparam int NL  = 3;
  localparam int STB = 2;
  localparam int FCW = 8;
  localparam int NS  = (HW + LW + SW - 1) / SW;

  logic           clk;
  logic           rst_n, start;
  logic [27:0]    base_lba;
  logic [FCW-1:0] fifo_count;
  logic [15:0]    fifo_data;
  logic           fifo_rd;
  logic [2:0]     ata_addr;
  logic [15:0]    ata_dout;
  logic           ata_dout_oe;
  logic [7:0]     ata_din;
  logic           ata_diow_n, ata_dior_n;
  logic           busy, line_done, fault;

  ata_seq_writer #(
    .LINE_WORDS(LW), .HDR_WORDS(HW), .SECT_WORDS(SW), .LINES(NL),
    .STROBE_CYC(STB), .FCW(FCW)
  ) i_ata_seq_writer (
    .clk(clk), .rst_n(rst_n), .start(start), .base_lba(base_lba),
    .fifo_count(fifo_count), .fifo_data(fifo_data), .fifo_rd(fifo_rd),
    .ata_addr(ata_addr), .ata_dout(ata_dout), .ata_dout_oe(ata_dout_oe),
    .ata_din(ata_din), .ata_diow_n(ata_diow_n), .ata_dior_n(ata_dior_n),
    .busy(busy), .line_done(line_done), .fault(fault)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int total = 0, bad = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // FIFO model (show-ahead)
  logic [15:0] fq[$];
  logic [15:0] xq[$];
  bit pop_pend = 0;
  int npop = 0;

  always @(posedge clk) if (fifo_rd) begin pop_pend = 1; npop++; end
  always @(negedge clk) begin
    if (pop_pend && fq.size() > 0) void'(fq.pop_front());
    pop_pend   = 0;
    fifo_count = FCW'(fq.size());
    fifo_data  = (fq.size() > 0) ? fq[0] : 16'h0000;
  end

  task automatic push_words(input int n);
    for (int i = 0; i < n; i++) begin
      logic [15:0] w;
      w = 16'($urandom);
      @(negedge clk);
      fq.push_back(w);
      xq.push_back(w);
    end
  endtask

  // Drive model
  bit armed = 0;
  int bsy_cnt = 3, drq_left = 0, secs_left = 0;
  bit err_inj = 0;
  logic [7:0] tf [8];
  logic [10:0] wlog[$];
  int viol_cmd = 0, viol_data = 0, viol_setup = 0, viol_width = 0;
  int lowcnt = 0, nstrobe = 0, cmd_cnt = 0, ndone = 0;
  int dpos = 0, dline = 0;
  logic [27:0] exp_lba;
  logic [2:0]  addr_prev;
  logic [15:0] dout_prev;

  initial ata_din = 8'h00;

  always @(negedge ata_dior_n) if (armed) begin
    nstrobe++;
    if (bsy_cnt > 0) begin
      ata_din = 8'h80;
      bsy_cnt--;
    end else begin
      ata_din = 8'h40 | ((drq_left > 0) ? 8'h08 : 8'h00) | (err_inj ? 8'h01 : 8'h00);
    end
  end

  always @(negedge clk) begin
    if (armed && !ata_diow_n) lowcnt++;
    addr_prev = ata_addr;
    dout_prev = ata_dout;
  end

  always @(posedge clk) if (line_done) ndone++;

  always @(negedge ata_diow_n) if (armed) begin
    nstrobe++;
    if (ata_addr != addr_prev || ata_dout != dout_prev) viol_setup++;
  end

  always @(posedge ata_diow_n) if (armed) begin
    logic [2:0]  a;
    logic [15:0] d, e;
    logic [27:0] got;
    a = ata_addr;
    d = ata_dout;
    if (lowcnt < STB) viol_width++;
    lowcnt = 0;
    if (a != 3'd0) begin
      tf[a] = d[7:0];
      wlog.push_back({a, d[7:0]});
      if (bsy_cnt > 0) viol_cmd++;
      if (a == 3'd7 && d[7:0] == 8'h30) begin
        cmd_cnt++;
        got = {tf[6][3:0], tf[5], tf[4], tf[3]};
        chk(tf[2] == 8'(NS), "R3 sector count", tf[2], NS);
        chk(tf[6][7:4] == 4'hE, "R3 device register mode bits", tf[6][7:4], 4'hE);
        chk(got == exp_lba, "R2 line start address", got, exp_lba);
        for (int k = 0; k < 6; k++)
          chk(wlog[wlog.size() - 6 + k][10:8] == 3'(k + 2), "R3 register order",
              wlog[wlog.size() - 6 + k][10:8], k + 2);
        exp_lba   = exp_lba + 28'(NS);
        secs_left = int'(tf[2]);
        drq_left  = SW;
        bsy_cnt   = $urandom_range(1, 3);
      end else if (a == 3'd7) begin
        bsy_cnt = $urandom_range(1, 3);
      end
    end else begin
      if (bsy_cnt > 0 || drq_left == 0) viol_data++;
      if (dpos < HW)           e = {4'(dpos), 12'(dline)};
      else if (dpos < HW + LW) e = (xq.size() > 0) ? xq.pop_front() : 16'hDEAD;
      else                     e = 16'h0000;
      chk(d == e, "R6 data word", d, e);
      dpos++;
      if (dpos == NS * SW) begin dpos = 0; dline++; end
      drq_left--;
      if (drq_left <= 0) begin
        drq_left = 0;
        secs_left--;
        if (secs_left > 0) drq_left = SW;
        bsy_cnt = $urandom_range(1, 3);
      end
    end
  end

  task automatic frame_start(input logic [27:0] b);
    @(negedge clk);
    base_lba = b;
    exp_lba  = b;
    dpos = 0; dline = 0; ndone = 0; npop = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(input int n);
    for (int i = 0; i < 20000 && ndone < n; i++) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
    report();
  end

  initial begin
    logic [10:0] iexp [4];
    int s0;
    void'($urandom(32'd7));
    rst_n = 1'b0; start = 1'b0; base_lba = 28'd0; exp_lba = 28'd0;
    fifo_count = '0; fifo_data = 16'h0;
    #1 armed = 1;
    repeat (3) @(negedge clk);
    chk(busy == 1'b0, "R9 busy low in reset", busy, 0);
    chk(fault == 1'b0, "R10 fault low in reset", fault, 0);
    chk(ata_diow_n && ata_dior_n, "R8 strobes idle in reset", {ata_diow_n, ata_dior_n}, 2'b11);
    chk(fifo_rd == 1'b0, "R7 no pop in reset", fifo_rd, 0);
    rst_n = 1'b1;

    // R1 init sequence
    for (int i = 0; i < 3000 && wlog.size() < 4; i++) @(negedge clk);
    repeat (60) @(negedge clk);
    iexp[0] = {3'd1, 8'h03}; iexp[1] = {3'd2, 8'h08};
    iexp[2] = {3'd6, 8'hE0}; iexp[3] = {3'd7, 8'hEF};
    chk(wlog.size() == 4, "R1 init write count", wlog.size(), 4);
    for (int i = 0; i < 4; i++)
      if (i < wlog.size()) chk(wlog[i] == iexp[i], "R1 init write", wlog[i], iexp[i]);
    chk(viol_cmd == 0, "R1 init waits for ready", viol_cmd, 0);
    chk(busy == 1'b0, "R1 idle after init", busy, 0);

    // Frame A: line 0 held one word short
    push_words(LW - 1);
    frame_start(28'($urandom) & 28'h0FFFFFF);
    repeat (300) @(negedge clk);
    chk(cmd_cnt == 0, "R7 no command before full line", cmd_cnt, 0);
    chk(busy == 1'b1, "R9 busy during frame", busy, 1);
    push_words(1);
    for (int l = 1; l < NL; l++) begin
      repeat ($urandom_range(0, 100)) @(negedge clk);
      push_words(LW);
    end
    wait_done(NL);
    repeat (20) @(negedge clk);
    chk(ndone == NL, "R9 line_done count", ndone, NL);
    chk(busy == 1'b0, "R9 busy low after frame", busy, 0);
    chk(npop == NL * LW, "R7 pops per frame", npop, NL * LW);
    chk(fq.size() == 0, "R7 FIFO drained", fq.size(), 0);
    chk(dline == NL, "R5 sectors per line", dline, NL);

    // Frame B: all lines queued, top address nibble set
    push_words(LW * NL);
    frame_start(28'hFFFFFF0);
    wait_done(NL);
    repeat (20) @(negedge clk);
    chk(ndone == NL, "R2 second frame lines", ndone, NL);
    chk(exp_lba == 28'hFFFFFF0 + 28'(NL * NS), "R2 sequential advance", exp_lba,
        28'hFFFFFF0 + 28'(NL * NS));
    chk(npop == NL * LW, "R7 pops second frame", npop, NL * LW);
    chk(busy == 1'b0, "R9 busy low after second frame", busy, 0);

    chk(viol_cmd == 0, "R4 task file written while drive busy", viol_cmd, 0);
    chk(viol_data == 0, "R5 data without ready request", viol_data, 0);
    chk(viol_setup == 0, "R8 address setup", viol_setup, 0);
    chk(viol_width == 0, "R8 strobe width", viol_width, 0);

    // R10 fault
    err_inj = 1;
    s0 = cmd_cnt;
    push_words(LW);
    frame_start(28'h0000100);
    repeat (200) @(negedge clk);
    chk(fault == 1'b1, "R10 fault raised", fault, 1);
    chk(busy == 1'b0, "R10 busy low on fault", busy, 0);
    chk(cmd_cnt == s0, "R10 no command after error", cmd_cnt, s0);
    s0 = nstrobe;
    err_inj = 0;
    repeat (100) @(negedge clk);
    chk(nstrobe == s0, "R10 bus quiet after fault", nstrobe, s0);
    chk(fault == 1'b1, "R10 fault sticky", fault, 1);
    report();
  end
endmodule